// File: doc/BRIEF.md
# Frame-Based Separation Sequencer

This block is the control sequencer for a two-channel feedback separation network made of a forward array and an update array. It works one frame at a time. A start request opens a frame. The frame then streams N samples through the forward array, using the weights made in the previous frame. Next, the update array runs over the buffered outputs at twice the rate. The frame closes with one atomic weight reload.

The first frame after reset is preceded by a one-cycle clearing step, which zeroes every weight and every element cost. Later frames skip that step, so each frame always starts from the weights the previous frame produced. The sequencer also supplies the address into the frame output buffer, and an even/odd phase bit that selects which half of the update elements is active. The arithmetic of the arrays is not part of this block.

Top module: `sep_frame_sequencer`

## Requirements
- R1: While reset is held and after it is released, `busy`, `clearAll`, `fwdEn`, `updEn`, `weightLoad` and `frameDone` are all low until a start request arrives.
- R2: The first start accepted after reset is followed by exactly one cycle with `clearAll` high, and then the forward phase begins. Every later start goes straight to the forward phase, with no clearing cycle.
- R3: The forward phase keeps `fwdEn` high for exactly N−1 consecutive cycles (time indices 1 to N−1). During that phase `bufAddr` equals the time index, so it reads 1, 2, …, N−1.
- R4: The update phase begins right after the forward phase and keeps `updEn` high for exactly 2N cycles (time indices N to 3N−1). During that phase `bufAddr` equals (t−N)/2 rounded down, so it reads 0,0,1,1,…,N−1,N−1.
- R5: `updPhase` is 0 in the first update cycle and changes value on every following update cycle.
- R6: `weightLoad` and `frameDone` are high together for exactly one cycle (time index 3N), right after the last update cycle. The block is idle in the next cycle.
- R7: No two of `clearAll`, `fwdEn`, `updEn` and `weightLoad` are ever high in the same cycle.
- R8: A start request while `busy` is high is ignored. `frameLen` is captured when a start is accepted, and later changes to it do not affect the running frame.
- R9: A `frameLen` value below 2 is treated as 2.
- R10: `busy` is high from the cycle after an accepted start through the reload cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to run one frame (sampled while idle) |
| frameLen | input | LEN_W | Frame length N in samples |
| clearAll | output | 1 | Zero all weights and element costs |
| fwdEn | output | 1 | Forward array enable |
| updEn | output | 1 | Update array enable |
| updPhase | output | 1 | Even/odd select for the update elements |
| bufAddr | output | LEN_W | Frame output buffer address |
| weightLoad | output | 1 | Parallel copy of the new weights into the forward array |
| frameDone | output | 1 | One-cycle end-of-frame pulse |
| busy | output | 1 | A frame is in progress |

## Verification
Every output is a registered-state decode, so the first result of an accepted start is due in the cycle after the clock edge that samples the start. After that, each frame step advances exactly one cycle per edge: an optional clear cycle, N−1 forward cycles, 2N update cycles, and one reload cycle. The driver releases `start` just after the sampling edge and pushes the whole per-cycle expected trace for that frame into a queue at that moment. The monitor pops one entry on each falling edge, which lines every comparison up with the cycle its value belongs to. When the queue is empty the monitor expects the idle outputs, which is how ignored starts and frame-length changes made mid-frame are shown to have no effect.

// File: rtl/sep_seq_pkg.sv
package sep_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_INIT = 3'd1,
    S_FWD  = 3'd2,
    S_UPD  = 3'd3,
    S_LOAD = 3'd4
  } seqState_t;

  // Strobes from the control FSM to the counter datapath
  typedef struct packed {
    logic latchLen;  // capture frame length
    logic loadT1;    // set time index to 1
    logic incT;      // advance time index
    logic clrPhase;  // zero the even/odd bit
    logic togPhase;  // flip the even/odd bit
    logic fwdMode;   // address = time index
    logic updMode;   // address = (t - N) / 2
  } seqStrobe_t;

endpackage

// File: rtl/sep_seq_dpath.sv
module sep_seq_dpath
  import sep_seq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strobe,
  input  logic [LEN_W-1:0] frameLen,
  output logic             fwdLast,
  output logic             updLast,
  output logic [LEN_W-1:0] bufAddr,
  output logic             updPhase
);
  localparam int T_W = LEN_W + 2;
  localparam logic [LEN_W-1:0] MIN_LEN = LEN_W'(2);

  logic [LEN_W-1:0] lenQ;
  logic [T_W-1:0]   tQ;
  logic             phaseQ;
  logic [LEN_W-1:0] lenClamped;
  logic [T_W-1:0]   lenExt;
  logic [T_W-1:0]   lenTriple;
  logic [T_W-1:0]   rdOff;
  logic [T_W-1:0]   halfOff;

  assign lenClamped = (frameLen < MIN_LEN) ? MIN_LEN : frameLen;
  assign lenExt     = T_W'(lenQ);
  assign lenTriple  = (lenExt << 1) + lenExt;
  assign rdOff      = tQ - lenExt;
  assign halfOff    = rdOff >> 1;

  assign fwdLast  = (tQ == lenExt - T_W'(1));
  assign updLast  = (tQ == lenTriple - T_W'(1));
  assign updPhase = phaseQ;

  always_comb begin
    if (strobe.fwdMode)      bufAddr = tQ[LEN_W-1:0];
    else if (strobe.updMode) bufAddr = halfOff[LEN_W-1:0];
    else                     bufAddr = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lenQ   <= MIN_LEN;
      tQ     <= '0;
      phaseQ <= 1'b0;
    end else begin
      if (strobe.latchLen) lenQ <= lenClamped;
      if (strobe.loadT1)     tQ <= T_W'(1);
      else if (strobe.incT)  tQ <= tQ + T_W'(1);
      if (strobe.clrPhase)      phaseQ <= 1'b0;
      else if (strobe.togPhase) phaseQ <= ~phaseQ;
    end
  end

  // R9: the captured length never falls below the minimum
  p_len_min_r9: assert property (@(posedge clk) disable iff (!rstN)
    lenQ >= MIN_LEN);

  // R8: the length stays fixed while the update phase runs
  p_len_stable_r8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.updMode && $past(strobe.updMode) |-> $stable(lenQ));

endmodule

// File: rtl/sep_seq_ctrl.sv
module sep_seq_ctrl
  import sep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       fwdLast,
  input  logic       updLast,
  output seqStrobe_t strobe,
  output logic       clearAll,
  output logic       fwdEn,
  output logic       updEn,
  output logic       weightLoad,
  output logic       frameDone,
  output logic       busy
);
  seqState_t stateQ, stateD;
  logic      freshQ;

  always_comb begin
    stateD = stateQ;
    strobe = '0;
    unique case (stateQ)
      S_IDLE: begin
        if (start) begin
          strobe.latchLen = 1'b1;
          strobe.loadT1   = 1'b1;
          stateD = freshQ ? S_INIT : S_FWD;
        end
      end
      S_INIT: stateD = S_FWD;
      S_FWD: begin
        strobe.fwdMode = 1'b1;
        strobe.incT    = 1'b1;
        if (fwdLast) begin
          strobe.clrPhase = 1'b1;
          stateD = S_UPD;
        end
      end
      S_UPD: begin
        strobe.updMode  = 1'b1;
        strobe.incT     = 1'b1;
        strobe.togPhase = 1'b1;
        if (updLast) stateD = S_LOAD;
      end
      S_LOAD: stateD = S_IDLE;
      default: stateD = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= S_IDLE;
      freshQ <= 1'b1;
    end else begin
      stateQ <= stateD;
      if (stateQ == S_INIT) freshQ <= 1'b0;
    end
  end

  assign clearAll   = (stateQ == S_INIT);
  assign fwdEn      = (stateQ == S_FWD);
  assign updEn      = (stateQ == S_UPD);
  assign weightLoad = (stateQ == S_LOAD);
  assign frameDone  = (stateQ == S_LOAD);
  assign busy       = (stateQ != S_IDLE);

  // R7: engine strobes never overlap
  p_excl_r7: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({clearAll, fwdEn, updEn, weightLoad}));

  // R2: clearing is followed directly by the forward phase
  p_clear_then_fwd_r2: assert property (@(posedge clk) disable iff (!rstN)
    clearAll |=> fwdEn);

  // R6: reload comes straight after the update phase, then idle
  p_load_after_upd_r6: assert property (@(posedge clk) disable iff (!rstN)
    weightLoad |-> $past(updEn));
  p_idle_after_load_r6: assert property (@(posedge clk) disable iff (!rstN)
    weightLoad |=> !busy);

  // R10: busy holds until the reload cycle
  p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    busy && !weightLoad |=> busy);

endmodule

// File: rtl/sep_frame_sequencer.sv
module sep_frame_sequencer
  import sep_seq_pkg::*;
#(
  parameter int LEN_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LEN_W-1:0] frameLen,
  output logic             clearAll,
  output logic             fwdEn,
  output logic             updEn,
  output logic             updPhase,
  output logic [LEN_W-1:0] bufAddr,
  output logic             weightLoad,
  output logic             frameDone,
  output logic             busy
);
  seqStrobe_t strobe;
  logic       fwdLast;
  logic       updLast;

  sep_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .fwdLast    (fwdLast),
    .updLast    (updLast),
    .strobe     (strobe),
    .clearAll   (clearAll),
    .fwdEn      (fwdEn),
    .updEn      (updEn),
    .weightLoad (weightLoad),
    .frameDone  (frameDone),
    .busy       (busy)
  );

  sep_seq_dpath #(.LEN_W(LEN_W)) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .frameLen (frameLen),
    .fwdLast  (fwdLast),
    .updLast  (updLast),
    .bufAddr  (bufAddr),
    .updPhase (updPhase)
  );

  // R5: the even/odd bit flips on every update cycle after the first
  p_phase_toggle_r5: assert property (@(posedge clk) disable iff (!rstN)
    updEn && $past(updEn) |-> updPhase != $past(updPhase));
  p_phase_first_r5: assert property (@(posedge clk) disable iff (!rstN)
    updEn && $past(fwdEn) |-> !updPhase);

  // R3: the forward address steps by one
  p_fwd_addr_r3: assert property (@(posedge clk) disable iff (!rstN)
    fwdEn && $past(fwdEn) |-> bufAddr == $past(bufAddr) + LEN_W'(1));

  // R4: the update address steps on even phases and holds on odd ones
  p_upd_addr_r4: assert property (@(posedge clk) disable iff (!rstN)
    updEn && $past(updEn) && !updPhase |-> bufAddr == $past(bufAddr) + LEN_W'(1));
  p_upd_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    updEn && $past(updEn) && updPhase |-> bufAddr == $past(bufAddr));

endmodule

// File: tb/sep_frame_sequencer_tb.sv
`timescale 1ns/1ps
module sep_frame_sequencer_tb;
  localparam int LEN_W = 12;

  typedef struct packed {
    logic clr, fwd, upd, ph, load, done, busy;
    logic [LEN_W-1:0] addr;
  } exp_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [LEN_W-1:0] frameLen = '0;
  logic clearAll, fwdEn, updEn, updPhase, weightLoad, frameDone, busy;
  logic [LEN_W-1:0] bufAddr;

  int checks = 0;
  int fails  = 0;
  bit monOn  = 1'b0;
  string ctxTag = "";
  exp_t q[$];

  always #4 clk = ~clk;

  sep_frame_sequencer #(.LEN_W(LEN_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .frameLen(frameLen),
    .clearAll(clearAll), .fwdEn(fwdEn), .updEn(updEn), .updPhase(updPhase),
    .bufAddr(bufAddr), .weightLoad(weightLoad), .frameDone(frameDone), .busy(busy)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s at %0t: actual %0d expected %0d", tag, ctxTag, $time, act, exp);
    end
  endtask

  // Monitor: one expected item per cycle, idle when the queue is empty
  always @(negedge clk) begin
    if (monOn) begin
      exp_t e;
      e = (q.size() != 0) ? q.pop_front() : '0;
      chk("R10 busy", busy, e.busy);
      chk("R2 clearAll", clearAll, e.clr);
      chk("R3 fwdEn", fwdEn, e.fwd);
      chk("R4 updEn", updEn, e.upd);
      chk("R6 weightLoad", weightLoad, e.load);
      chk("R6 frameDone", frameDone, e.done);
      chk("R7 exclusive", $countones({clearAll, fwdEn, updEn, weightLoad}) <= 1, 1);
      if (e.upd) chk("R5 updPhase", updPhase, e.ph);
      if (e.fwd) chk("R3 bufAddr", bufAddr, e.addr);
      if (e.upd) chk("R4 bufAddr", bufAddr, e.addr);
    end
  end

  // Driver: pulse start, then push the frame's expected trace
  task automatic run_frame(input int n, input bit fresh, input bit poke);
    int ne;
    exp_t e;
    ne = (n < 2) ? 2 : n;   // R9 clamp
    @(posedge clk); #2;
    frameLen = LEN_W'(n);
    start = 1'b1;
    @(posedge clk); #2;
    start = 1'b0;
    if (fresh) begin
      e = '0; e.clr = 1'b1; e.busy = 1'b1; q.push_back(e);
    end
    for (int t = 1; t < ne; t++) begin
      e = '0; e.fwd = 1'b1; e.busy = 1'b1; e.addr = LEN_W'(t); q.push_back(e);
    end
    for (int k = 0; k < 2 * ne; k++) begin
      e = '0; e.upd = 1'b1; e.busy = 1'b1; e.ph = k[0]; e.addr = LEN_W'(k >> 1);
      q.push_back(e);
    end
    e = '0; e.load = 1'b1; e.done = 1'b1; e.busy = 1'b1; q.push_back(e);
    if (poke) begin
      // R8: start and a new length mid-frame must change nothing
      repeat (4) @(posedge clk);
      #2; start = 1'b1; frameLen = LEN_W'(3);
      @(posedge clk); #2; start = 1'b0;
      repeat (3) @(posedge clk);
      #2; start = 1'b1;
      @(posedge clk); #2; start = 1'b0;
    end
    wait (q.size() == 0);
    repeat (3) @(posedge clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #1_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired at %0t: actual running expected done", $time);
    finish_run();
  end

  initial begin
    // R1: outputs idle under reset
    repeat (3) @(posedge clk);
    #2;
    chk("R1 busy", busy, 0);
    chk("R1 enables", {clearAll, fwdEn, updEn, weightLoad, frameDone}, 0);
    rstN = 1'b1;
    monOn = 1'b1;
    repeat (4) @(posedge clk);   // R1: idle checked by monitor after release
    ctxTag = "R2 first frame";   run_frame(5, 1'b1, 1'b0);
    ctxTag = "R2 no clear";      run_frame(3, 1'b0, 1'b0);
    ctxTag = "R9 len one";       run_frame(1, 1'b0, 1'b0);
    ctxTag = "R9 len zero";      run_frame(0, 1'b0, 1'b0);
    ctxTag = "R8 ignore";        run_frame(8, 1'b0, 1'b1);
    ctxTag = "R4 len two";       run_frame(2, 1'b0, 1'b0);
    ctxTag = "R3 long";          run_frame(17, 1'b0, 1'b0);
    finish_run();
  end

endmodule